// File: doc/BRIEF.md
# Token-Based Sparse Column Readout

This block drains zero-suppressed hits from an array of pixel columns. Each column keeps a small ring of hit sets. A set is a row bitmap tagged with a crossing number and an amplitude value. Readout uses two tokens. A horizontal token crosses the columns in ascending index order and stops only at columns that hold an unread set. Inside the chosen column, a vertical token jumps from one hit row to the next and never visits a row without a hit. Each transfer places one hit word on a streaming output. The handoff from the last hit of one column to the first hit of the next column costs no cycle.

A loader writes one set per cycle through the load port: a column number, a row bitmap, a crossing tag and an amplitude. The output is a valid/ready stream. A word stays unchanged while it is valid and not yet accepted, and the whole readout machine waits during that time. `ld_ready` is a function of the current `ld_col` and the stored state only. A loader may look at it before it asserts `ld_valid`. A load that is presented while `ld_ready` is low is dropped, not held. `ld_drop` reports it one cycle later. Each column also shows a two-bit readout state, so a monitor can follow the sweep.

Top module: `sparse_token_readout`

## Requirements
- R1: After reset, `out_valid` and `ld_drop` are 0, every `col_state` field is 00, and `ld_ready` is 1 for any column index below NCOL.
- R2: A set produces exactly one word for each set bit of its bitmap, in ascending row order. The word is {row index, column index, crossing tag, amplitude} from MSB to LSB, with widths clog2(NROW), clog2(NCOL), TAG_W and ADC_W.
- R3: If the token is idle and a set is accepted at clock edge k, its first word is valid right after edge k+2.
- R4: Within a sweep, columns are served in ascending index order, one set per column. The words of consecutive columns follow each other with no empty cycle.
- R5: When a sweep ends and sets are still pending, exactly two cycles with `out_valid` low come before the first word of the next sweep.
- R6: A column hands out its sets oldest first. A set that is loaded into a column the token has already passed waits for the next sweep.
- R7: `ld_ready` is 0 when the addressed column already holds NSET unread sets, or when `ld_col` >= NCOL. A load presented in that state is discarded and sets `ld_drop` to 1 for the following cycle. No stored data changes.
- R8: A set becomes free again on the clock edge that emits its last word. From the next cycle on, `ld_ready` for that column reflects the freed slot.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold and no word is lost or repeated.
- R10: A load with an all-zero bitmap is accepted. It occupies no set and produces no word.
- R11: Bits [2c+1:2c] of `col_state` give the state of column c: 00 = no pending set, 01 = pending and waiting for the token, 10 = being read in this cycle, 11 = pending but already passed by the token in the current sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A set is presented on the load port |
| ld_ready | output | 1 | The addressed column can take a set |
| ld_col | input | clog2(NCOL) | Target column of the load |
| ld_map | input | NROW | Hit bitmap, bit r = row r was hit |
| ld_tag | input | TAG_W | Crossing tag stored with the set |
| ld_adc | input | ADC_W | Amplitude stored with the set |
| ld_drop | output | 1 | A load was refused in the previous cycle |
| out_valid | output | 1 | `out_data` holds a hit word |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | clog2(NROW)+clog2(NCOL)+TAG_W+ADC_W | Hit word |
| col_state | output | 2*NCOL | Readout state of each column |

## Verification
The bench builds the block with five columns, eight rows, two sets per column, a four-bit tag and a three-bit amplitude. With only eight rows, every one of the 255 non-empty bitmaps can be loaded into every column. Each of these loads has its word sequence and its cycle timing checked against arithmetic expectations. With two sets per column, a third load refuses after two cycles, so refusal and slot release are easy to reach. With five columns, a sweep, its end gap, a set left behind the token and the per-column states all fit into a short, hand-computed cycle pattern.

// File: rtl/sro_pkg.sv
package sro_pkg;
  typedef enum logic {TK_IDLE = 1'b0, TK_SCAN = 1'b1} tk_mode_e;
  localparam logic [1:0] CS_NONE   = 2'b00;
  localparam logic [1:0] CS_WAIT   = 2'b01;
  localparam logic [1:0] CS_TALK   = 2'b10;
  localparam logic [1:0] CS_PASSED = 2'b11;
endpackage

// File: rtl/sro_first.sv
// Lowest-index set bit finder.
module sro_first #(
  parameter int W  = 8,
  parameter int IW = 3
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/sro_colbuf.sv
// Per-column ring of hit sets, read oldest first.
module sro_colbuf #(
  parameter int NROW  = 128,
  parameter int NSET  = 4,
  parameter int TAG_W = 8,
  parameter int ADC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [NROW-1:0]  push_map,
  input  logic [TAG_W-1:0] push_tag,
  input  logic [ADC_W-1:0] push_adc,
  input  logic             pop,
  output logic             room,
  output logic             pending,
  output logic [NROW-1:0]  head_map,
  output logic [TAG_W-1:0] head_tag,
  output logic [ADC_W-1:0] head_adc
);
  localparam int PW   = (NSET > 1) ? $clog2(NSET) : 1;
  localparam int CNTW = $clog2(NSET + 1);

  logic [NROW-1:0]  map_q [NSET];
  logic [TAG_W-1:0] tag_q [NSET];
  logic [ADC_W-1:0] adc_q [NSET];
  logic [PW-1:0]    wp_q, rp_q;
  logic [CNTW-1:0]  cnt_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(NSET - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= bump(wp_q);
      if (pop)  rp_q <= bump(rp_q);
      cnt_q <= cnt_q + CNTW'(push) - CNTW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      map_q[wp_q] <= push_map;
      tag_q[wp_q] <= push_tag;
      adc_q[wp_q] <= push_adc;
    end
  end

  assign room     = (cnt_q != CNTW'(NSET));
  assign pending  = (cnt_q != '0);
  assign head_map = map_q[rp_q];
  assign head_tag = tag_q[rp_q];
  assign head_adc = adc_q[rp_q];

  // R7
  push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> room);
  // R8
  pop_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> pending);
endmodule

// File: rtl/sparse_token_readout.sv
module sparse_token_readout
  import sro_pkg::*;
#(
  parameter int NCOL  = 22,
  parameter int NROW  = 128,
  parameter int NSET  = 4,
  parameter int TAG_W = 8,
  parameter int ADC_W = 3,
  localparam int RW     = $clog2(NROW),
  localparam int CW     = $clog2(NCOL),
  localparam int WORD_W = RW + CW + TAG_W + ADC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [CW-1:0]     ld_col,
  input  logic [NROW-1:0]   ld_map,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [ADC_W-1:0]  ld_adc,
  output logic              ld_drop,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic [2*NCOL-1:0] col_state
);
  localparam int FW = CW + 1;

  logic [NCOL-1:0]  room, pend, push, pop, cand, talk;
  logic [NROW-1:0]  hmap [NCOL];
  logic [TAG_W-1:0] htag [NCOL];
  logic [ADC_W-1:0] hadc [NCOL];

  tk_mode_e         mode_q;
  logic [FW-1:0]    from_q;
  logic [NROW-1:0]  rem_q;
  logic [CW-1:0]    tcol_q;
  logic [TAG_W-1:0] ttag_q;
  logic [ADC_W-1:0] tadc_q;

  logic             ld_in, adv, rem_any, cfound, rfound, emit_ok, emit;
  logic [CW-1:0]    cidx, emit_col;
  logic [RW-1:0]    ridx;
  logic [NROW-1:0]  sel_map, src_map, next_rem;
  logic [TAG_W-1:0] sel_tag, emit_tag;
  logic [ADC_W-1:0] sel_adc, emit_adc;

  assign ld_in = ({1'b0, ld_col} < FW'(NCOL));

  always_comb begin
    ld_ready = 1'b0;
    for (int c = 0; c < NCOL; c++)
      if (ld_in && ld_col == CW'(c)) ld_ready = room[c];
  end

  // Column buffers and horizontal-token candidates
  for (genvar c = 0; c < NCOL; c++) begin : g_col
    assign push[c] = ld_valid && ld_ready && (ld_col == CW'(c)) && (|ld_map);
    assign cand[c] = pend[c] && (FW'(c) >= from_q);
    assign pop[c]  = emit && (next_rem == '0) && (emit_col == CW'(c));
    assign talk[c] = (mode_q == TK_SCAN) && emit_ok && (emit_col == CW'(c));

    sro_colbuf #(.NROW(NROW), .NSET(NSET), .TAG_W(TAG_W), .ADC_W(ADC_W)) u_buf (
      .clk(clk), .rst_n(rst_n),
      .push(push[c]), .push_map(ld_map), .push_tag(ld_tag), .push_adc(ld_adc),
      .pop(pop[c]), .room(room[c]), .pending(pend[c]),
      .head_map(hmap[c]), .head_tag(htag[c]), .head_adc(hadc[c])
    );
  end

  // Horizontal token: first waiting column at or after the sweep position
  sro_first #(.W(NCOL), .IW(CW)) u_csel (.vec(cand), .found(cfound), .idx(cidx));

  always_comb begin
    sel_map = '0;
    sel_tag = '0;
    sel_adc = '0;
    for (int c = 0; c < NCOL; c++) begin
      if (cidx == CW'(c)) begin
        sel_map = hmap[c];
        sel_tag = htag[c];
        sel_adc = hadc[c];
      end
    end
  end

  // Vertical token: next hit row of the active set
  assign rem_any = |rem_q;
  assign src_map = rem_any ? rem_q : sel_map;

  sro_first #(.W(NROW), .IW(RW)) u_rsel (.vec(src_map), .found(rfound), .idx(ridx));

  assign next_rem = src_map & ~(NROW'(1) << ridx);
  assign emit_col = rem_any ? tcol_q : cidx;
  assign emit_tag = rem_any ? ttag_q : sel_tag;
  assign emit_adc = rem_any ? tadc_q : sel_adc;
  assign emit_ok  = (rem_any || cfound) && rfound;
  assign adv      = !out_valid || out_ready;
  assign emit     = adv && (mode_q == TK_SCAN) && emit_ok;

  always_comb begin
    for (int c = 0; c < NCOL; c++) begin
      if (talk[c])                                      col_state[2*c +: 2] = CS_TALK;
      else if (!pend[c])                                col_state[2*c +: 2] = CS_NONE;
      else if (mode_q == TK_SCAN && FW'(c) < from_q)    col_state[2*c +: 2] = CS_PASSED;
      else                                              col_state[2*c +: 2] = CS_WAIT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= TK_IDLE;
      from_q    <= '0;
      rem_q     <= '0;
      tcol_q    <= '0;
      ttag_q    <= '0;
      tadc_q    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      ld_drop   <= 1'b0;
    end else begin
      ld_drop <= ld_valid && !ld_ready;
      if (adv) begin
        out_valid <= 1'b0;
        if (mode_q == TK_IDLE) begin
          if (|pend) begin
            mode_q <= TK_SCAN;
            from_q <= '0;
          end
        end else if (emit_ok) begin
          out_valid <= 1'b1;
          out_data  <= {ridx, emit_col, emit_tag, emit_adc};
          rem_q     <= next_rem;
          if (!rem_any) begin
            tcol_q <= cidx;
            ttag_q <= sel_tag;
            tadc_q <= sel_adc;
            from_q <= FW'(cidx) + FW'(1);
          end
        end else begin
          mode_q <= TK_IDLE;
        end
      end
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R7
  refuse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && !ld_ready |=> ld_drop);
  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == TK_IDLE) |=> !out_valid);
  // R2
  col_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ({1'b0, out_data[TAG_W+ADC_W +: CW]} < FW'(NCOL)));
endmodule

// File: tb/sparse_token_readout_tb.sv
`timescale 1ns/1ps
module sparse_token_readout_tb;
  localparam int NCOL = 5, NROW = 8, NSET = 2, TAG_W = 4, ADC_W = 3;
  localparam int WW = 3 + 3 + TAG_W + ADC_W;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          ld_valid = 1'b0, ld_ready, ld_drop, out_valid, out_ready = 1'b1;
  logic [2:0]    ld_col = '0;
  logic [7:0]    ld_map = '0;
  logic [3:0]    ld_tag = '0;
  logic [2:0]    ld_adc = '0;
  logic [WW-1:0] out_data;
  logic [9:0]    col_state;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0, rec_on = 1'b0;
  int rec_n = -1, nw = 0;
  logic [WW-1:0] wv [64];
  int wc [64];

  always #2 clk = ~clk;

  sparse_token_readout #(.NCOL(NCOL), .NROW(NROW), .NSET(NSET), .TAG_W(TAG_W), .ADC_W(ADC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_col(ld_col),
    .ld_map(ld_map), .ld_tag(ld_tag), .ld_adc(ld_adc), .ld_drop(ld_drop),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .col_state(col_state)
  );

  // handshake recorder, sampled just after the falling edge
  always begin
    @(negedge clk);
    #1;
    if (rec_on) begin
      rec_n++;
      if (out_valid && out_ready && nw < 64) begin
        wv[nw] = out_data;
        wc[nw] = rec_n;
        nw++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] mkw(input int row, input int col, input int tag, input int adc);
    return {3'(row), 3'(col), 4'(tag), 3'(adc)};
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rec_start();
    rec_n = -1;
    nw = 0;
    rec_on = 1'b1;
  endtask

  task automatic do_load(input int col, input int map, input int tag, input int adc, output logic rdy);
    ld_valid = 1'b1;
    ld_col = 3'(col);
    ld_map = 8'(map);
    ld_tag = 4'(tag);
    ld_adc = 3'(adc);
    #1 rdy = ld_ready;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  logic rdy;

  initial begin
    step(4);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 ld_drop", 32'(ld_drop), 0);
    chk("R1 col_state", 32'(col_state), 0);
    chk("R1 ld_ready", 32'(ld_ready), 1);
    step(1);

    // R2/R3 exhaustive: every non-empty bitmap on every column
    for (int col = 0; col < NCOL; col++) begin
      for (int map = 1; map < 256; map++) begin
        int tag, adc, k;
        tag = (col * 7 + map) % 16;
        adc = map % 8;
        rec_start();
        do_load(col, map, tag, adc, rdy);
        step(13);
        chk("R2 word count", 32'(nw), 32'($countones(8'(map))));
        k = 0;
        for (int r = 0; r < 8; r++) begin
          if (map[r] && k < nw) begin
            chk("R2 word", 32'(wv[k]), 32'(mkw(r, col, tag, adc)));
            chk("R3 R4 word cycle", 32'(wc[k]), 32'(3 + k));
            k++;
          end
        end
      end
    end
    rec_on = 1'b0;
    step(3);

    // R4 R5 R6 R11: sweep order, end gap, set left behind the token
    rec_start();
    do_load(0, 8'h0F, 1, 1, rdy);
    do_load(1, 8'h03, 2, 2, rdy);
    do_load(0, 8'h81, 3, 3, rdy);
    do_load(4, 8'h10, 4, 4, rdy);
    step(2);
    #1;
    chk("R11 col_state mid sweep", 32'(col_state), 32'(10'b01_00_00_10_11));
    step(14);
    chk("R4 R5 word count", 32'(nw), 9);
    begin
      logic [WW-1:0] ew [9];
      int ec [9];
      ew = '{mkw(0,0,1,1), mkw(1,0,1,1), mkw(2,0,1,1), mkw(3,0,1,1), mkw(0,1,2,2),
             mkw(1,1,2,2), mkw(4,4,4,4), mkw(0,0,3,3), mkw(7,0,3,3)};
      ec = '{3, 4, 5, 6, 7, 8, 9, 12, 13};
      for (int i = 0; i < 9; i++) begin
        chk("R4 R6 sweep word", 32'(wv[i]), 32'(ew[i]));
        chk("R4 R5 sweep cycle", 32'(wc[i]), 32'(ec[i]));
      end
    end
    chk("R11 col_state drained", 32'(col_state), 0);
    rec_on = 1'b0;
    step(2);

    // R7 R8 R6: refusal when full, slot freed at last word
    rec_start();
    do_load(3, 8'h03, 5, 5, rdy);
    chk("R7 first accept", 32'(rdy), 1);
    do_load(3, 8'h03, 6, 5, rdy);
    chk("R7 second accept", 32'(rdy), 1);
    do_load(3, 8'hFF, 9, 1, rdy);
    chk("R7 full refuse", 32'(rdy), 0);
    #1;
    chk("R7 ld_drop", 32'(ld_drop), 1);
    chk("R8 still full", 32'(ld_ready), 0);
    step(1);
    #1;
    chk("R8 slot freed", 32'(ld_ready), 1);
    chk("R7 drop cleared", 32'(ld_drop), 0);
    step(10);
    chk("R7 word count", 32'(nw), 4);
    chk("R6 w0", 32'(wv[0]), 32'(mkw(0,3,5,5)));
    chk("R6 w1", 32'(wv[1]), 32'(mkw(1,3,5,5)));
    chk("R6 w2", 32'(wv[2]), 32'(mkw(0,3,6,5)));
    chk("R6 w3", 32'(wv[3]), 32'(mkw(1,3,6,5)));
    chk("R5 R6 second sweep cycle", 32'(wc[2]), 7);
    rec_on = 1'b0;
    step(2);

    // R9 back-pressure
    out_ready = 1'b0;
    rec_start();
    do_load(1, 8'hA5, 6, 2, rdy);
    step(2);
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R9 stall valid", 32'(out_valid), 1);
      chk("R9 stall data", 32'(out_data), 32'(mkw(0,1,6,2)));
      chk("R11 talking during stall", 32'(col_state[3:2]), 32'(2'b10));
      step(1);
    end
    out_ready = 1'b1;
    step(8);
    chk("R9 word count", 32'(nw), 4);
    chk("R9 w0", 32'(wv[0]), 32'(mkw(0,1,6,2)));
    chk("R9 w1", 32'(wv[1]), 32'(mkw(2,1,6,2)));
    chk("R9 w2", 32'(wv[2]), 32'(mkw(5,1,6,2)));
    chk("R9 w3", 32'(wv[3]), 32'(mkw(7,1,6,2)));
    chk("R9 resume cycle", 32'(wc[0]), 6);
    rec_on = 1'b0;
    step(2);

    // R10 empty bitmaps
    rec_start();
    do_load(2, 0, 7, 7, rdy);
    chk("R10 accept 1", 32'(rdy), 1);
    do_load(2, 0, 7, 7, rdy);
    chk("R10 accept 2", 32'(rdy), 1);
    #1;
    chk("R10 ready kept", 32'(ld_ready), 1);
    chk("R10 no drop", 32'(ld_drop), 0);
    chk("R10 col_state", 32'(col_state), 0);
    step(8);
    chk("R10 no words", 32'(nw), 0);

    // R7 out-of-range column
    do_load(5, 8'hFF, 1, 1, rdy);
    chk("R7 col 5 refused", 32'(rdy), 0);
    #1;
    chk("R7 col 5 drop", 32'(ld_drop), 1);
    do_load(7, 8'h01, 1, 1, rdy);
    chk("R7 col 7 refused", 32'(rdy), 0);
    step(8);
    chk("R7 out-of-range no words", 32'(nw), 0);
    chk("R7 out-of-range col_state", 32'(col_state), 0);
    rec_on = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule